// File: doc/BRIEF.md
# Keyed Register Write-Unlock Controller

This block protects a small bank of slow-domain control registers from stray writes. A host bus reads and writes three kinds of location: a control/status word, an unlock word, and the guarded data words. Before a guarded word can change, software has to complete a handshake. It waits for the ready flag, writes a 32-bit key to the unlock word, and waits for the enable flag. It then waits for ready again and only after that writes the guarded word.

The slow synchronising domain is modelled as a fixed busy window. After every accepted write the ready flag stays low for `LATENCY` cycles. A write that breaks the sequence is dropped and latches a sticky error flag, which only reset clears. Reads are free at any time and never disturb the unlock state.

Address map (word addresses): 0 is control/status, 1 is unlock, and 2 to 2+`N_GUARD`-1 are the guarded words. Every other address is unmapped and reads as zero.

Top module: `keyed_write_gate`

## Requirements
- R1: Reset state. Control reads 0x00000080, meaning ready (bit 7) is 1 and error (bit 0) is 0. Unlock reads 0 and every guarded word reads 0.
- R2: An unlock write of exactly 0x0000A55A while ready is 1 sets the enable flag. The unlock word then reads 0x80000000 (enable is bit 31, all other bits are 0).
- R3: An unlock write of any other value while ready is 1 clears enable. This includes a value that differs from the key only in its upper 16 bits.
- R4: After an accepted write at clock edge E, ready reads 0 after edges E+1 to E+LATENCY-1 and reads 1 after edge E+LATENCY (LATENCY defaults to 4).
- R5: A guarded write with enable=1 and ready=1 stores the data. The data reads back at its address.
- R6: A guarded write with enable=0 or ready=0 leaves the guarded word unchanged and does not start a busy window. It sets error bit 0, which stays 1 until reset.
- R7: An unlock write while ready=0 is dropped: enable keeps its value. It also sets the sticky error bit.
- R8: Enable stays 1 across any number of accepted guarded writes.
- R9: Reads have no side effects. Writes to the control word or to unmapped addresses change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Word address of the combinational read |
| rd_data | output | 32 | Read data for rd_addr |

## Verification
Guarded writes are tried in four states: locked, unlocked and idle, unlocked but still busy, and relocked after a wrong key. These states show that acceptance depends on enable and ready together, not on either one alone. Two unlock values are tried: the exact key and a near-miss that differs only in its upper half. This shows that all 32 bits are compared. The busy window is sampled cycle by cycle after an accepted write, which pins its exact length. A wrong key sent during the busy window shows that writes to the unlock word are also gated by ready.

// File: rtl/keyed_gate_pkg.sv
package keyed_gate_pkg;
    localparam int          DATA_W      = 32;
    localparam logic [31:0] UNLOCK_KEY  = 32'h0000_A55A;
    localparam int          CTRL_ADDR   = 0;
    localparam int          UNLOCK_ADDR = 1;
    localparam int          GUARD_BASE  = 2;
    localparam int          READY_BIT   = 7;
    localparam int          ERR_BIT     = 0;
    localparam int          ENABLE_BIT  = 31;

    typedef struct packed {
        logic enable;
    } key_state_t;

    typedef struct packed {
        logic err;
    } gate_state_t;
endpackage

// File: rtl/busy_timer.sv
module busy_timer #(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);
    localparam int CW = $clog2(LATENCY + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CW'(LATENCY);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);

    assert_busy_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);
    assert_busy_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !ready) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/key_keeper.sv
module key_keeper
    import keyed_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unl_wr,
    input  logic              ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              enable
);
    key_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (unl_wr && ready)
            st_d.enable = (wr_data == UNLOCK_KEY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable = st_q.enable;

    assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (unl_wr && ready && wr_data == UNLOCK_KEY) |=> enable);
    assert_bad_key_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (unl_wr && ready && wr_data != UNLOCK_KEY) |=> !enable);
    assert_busy_unlock_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (unl_wr && !ready) |=> $stable(enable));
endmodule

// File: rtl/guard_bank.sv
module guard_bank
    import keyed_gate_pkg::*;
#(
    parameter int N_GUARD = 4,
    parameter int AW      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    input  logic [AW-1:0]     rd_addr,
    output logic              wr_hit,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_word
);
    logic [N_GUARD-1:0][DATA_W-1:0] regs_d, regs_q;
    logic [N_GUARD-1:0]             wsel, rsel;

    for (genvar g = 0; g < N_GUARD; g++) begin : g_dec
        assign wsel[g] = (wr_addr == AW'(GUARD_BASE + g));
        assign rsel[g] = (rd_addr == AW'(GUARD_BASE + g));
    end

    assign wr_hit = |wsel;
    assign rd_hit = |rsel;

    always_comb begin
        regs_d  = regs_q;
        rd_word = '0;
        for (int i = 0; i < N_GUARD; i++) begin
            if (commit && wsel[i]) regs_d[i] = wr_data;
            if (rsel[i])           rd_word  = regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assert_hold_without_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(regs_q));
    assert_one_word_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wsel));
endmodule

// File: rtl/keyed_write_gate.sv
module keyed_write_gate
    import keyed_gate_pkg::*;
#(
    parameter int N_GUARD = 4,
    parameter int LATENCY = 4,
    parameter int AW      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int TOP_ADDR = GUARD_BASE + N_GUARD - 1;

    logic        ready, enable;
    logic        unl_wr, grd_hit, grd_wr, grd_ok, unl_ok, bad, start;
    logic        rd_hit;
    logic [DATA_W-1:0] grd_word;
    gate_state_t st_d, st_q;

    assign unl_wr = wr_en && (wr_addr == AW'(UNLOCK_ADDR));
    assign grd_wr = wr_en && grd_hit;
    assign unl_ok = unl_wr && ready;
    assign grd_ok = grd_wr && ready && enable;
    assign bad    = (unl_wr && !ready) || (grd_wr && !(ready && enable));
    assign start  = unl_ok || grd_ok;

    busy_timer #(.LATENCY(LATENCY)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready)
    );

    key_keeper u_key (
        .clk(clk), .rst_n(rst_n), .unl_wr(unl_wr), .ready(ready),
        .wr_data(wr_data), .enable(enable)
    );

    guard_bank #(.N_GUARD(N_GUARD), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit(grd_ok), .rd_addr(rd_addr), .wr_hit(grd_hit),
        .rd_hit(rd_hit), .rd_word(grd_word)
    );

    always_comb begin
        st_d = st_q;
        if (bad) st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(CTRL_ADDR)) begin
            rd_data[READY_BIT] = ready;
            rd_data[ERR_BIT]   = st_q.err;
        end else if (rd_addr == AW'(UNLOCK_ADDR)) begin
            rd_data[ENABLE_BIT] = enable;
        end else if (rd_hit) begin
            rd_data = grd_word;
        end
    end

    initial assert (TOP_ADDR < (1 << AW));

    assert_bad_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grd_wr && !(ready && enable)) |=> st_q.err);
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);
    assert_busy_unlock_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (unl_wr && !ready) |=> st_q.err);
    assert_enable_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !unl_wr) |=> enable);
endmodule

// File: tb/keyed_write_gate_bench.sv
module keyed_write_gate_bench;
    localparam int AW  = 3;
    localparam int LAT = 4;
    localparam logic [31:0] KEY = 32'h0000_A55A;

    logic clk = 0, rst_n = 0, wr_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0]   wr_data = '0, rd_data;

    always #2 clk = ~clk;

    keyed_write_gate #(.N_GUARD(4), .LATENCY(LAT), .AW(AW)) u_keyed_write_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // Monitor: compare at the falling edge after the driver has set rd_addr
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_vec++;
            if (rd_data !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %08h expected %08h", it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic expect_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        rd_addr = a;
        it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        idle(2);
        rst_n = 1;
        expect_rd(0, 32'h80, "R1 ctrl");
        expect_rd(1, 32'h0, "R1 unlock");
        expect_rd(2, 32'h0, "R1 guard0");
        expect_rd(5, 32'h0, "R1 guard3");

        // R2 key accepted, then R4 busy length sampled each cycle
        wr(1, KEY);
        for (int i = 1; i <= LAT; i++)
            expect_rd(0, (i < LAT) ? 32'h0 : 32'h80, "R4 ready window");
        expect_rd(1, 32'h8000_0000, "R2 enable set");

        // R5 accepted guarded writes; R8 enable persists
        wr(2, 32'hCAFE_0001);
        idle(LAT);
        wr(5, 32'h5555_AAAA);
        idle(LAT);
        expect_rd(2, 32'hCAFE_0001, "R5 guard0");
        expect_rd(5, 32'h5555_AAAA, "R5 guard3");
        expect_rd(1, 32'h8000_0000, "R8 enable kept");
        expect_rd(1, 32'h8000_0000, "R9 read no effect");
        expect_rd(0, 32'h80, "R6 no error yet");

        // R6 guarded write while busy dropped
        wr(1, KEY);
        wr(3, 32'h2222_2222);
        idle(LAT);
        expect_rd(3, 32'h0, "R6 busy write dropped");
        expect_rd(0, 32'h81, "R6 error set, no busy");

        // R7 wrong key during busy is dropped
        wr(1, KEY);
        wr(1, 32'hDEAD_BEEF);
        idle(LAT);
        expect_rd(1, 32'h8000_0000, "R7 busy unlock dropped");

        // R3 near-miss key relocks
        wr(1, 32'h0001_A55A);
        idle(LAT);
        expect_rd(1, 32'h0, "R3 enable cleared");
        wr(4, 32'h7777_7777);
        expect_rd(0, 32'h81, "R6 locked write no busy");
        expect_rd(4, 32'h0, "R6 locked write dropped");

        // R9 writes to control and unmapped addresses
        wr(0, 32'h0);
        wr(7, 32'hFFFF_FFFF);
        expect_rd(0, 32'h81, "R9 ctrl write ignored");
        expect_rd(7, 32'h0, "R9 unmapped");
        expect_rd(2, 32'hCAFE_0001, "R9 guard0 intact");

        // R1 reset clears sticky error
        idle(1);
        rst_n = 0;
        idle(1);
        rst_n = 1;
        expect_rd(0, 32'h80, "R1 ctrl after reset");
        expect_rd(2, 32'h0, "R1 guard0 after reset");
        idle(2);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule